// File: doc/BRIEF.md
# Cache Line Lock Controller

This block holds the tag, valid and lock state of a small set-associative first-level cache and decides, for each incoming request, what happens to the addressed line. It handles three request kinds. A fill brings in an ordinary line. A lock-set pins a line so replacement can never evict it. A lock-clear releases a pinned line. For each request the block either reports a hit, allocates a way, or sends the line around the cache to the write buffer as a normal burst write. Locked ways are never chosen as victims.

Failed lock attempts raise no exception. They are reported through two sticky status flags. The overlock flag means every way of the target set was already locked. The unable flag means the lock request was illegal for its attributes. Software clears each flag with a one-cycle pulse. Data arrays, bus traffic and exception handling live outside this block.

Requests and results flow as valid/ready streams, with a single registered result stage between them. The rules are:
- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the result stage is empty or is being drained in the same cycle.
- A result is presented with `res_valid`. It stays unchanged until a clock edge on which `res_ready` is high.

All state changes take effect on the edge that accepts the request.

Top module: `cl_lock_ctrl`

## Requirements
- R1: After reset, every line is invalid and unlocked, every replacement pointer is 0, both flags are 0, `res_valid` is 0 and `req_ready` is 1.
- R2: Encodings:
  - Request type: fill=0, lock-set=1, lock-clear=2, 3=reserved.
  - Result kind: none=0, hit=1, alloc=2, bypass=3.
  - Address: set index at `req_addr[7:4]`, tag at `req_addr[15:8]`.
  - Victim choice: on a miss that allocates, the lowest-numbered invalid way is taken. If no way is invalid, the victim is the first unlocked way found scanning upward, with wraparound, from the set's pointer. After any allocation the pointer becomes victim+1 modulo the way count. `res_way` reports the way for hit and alloc results.
- R3: A fill that hits, with the cache enabled and the line cacheable, returns hit and changes nothing. A reserved request type returns none and changes nothing.
- R4: A fill miss that allocates stores the tag, marks the way valid and unlocked, and returns alloc. A lock-set miss that allocates does the same but marks the way locked. A lock-set hit sets the way's lock bit and returns hit.
- R5: A valid lock-set (`req_ct`=0) that misses in a set whose ways are all locked returns none, allocates nothing, and sets the overlock flag.
- R6: A lock-set fails, returning none, changing no line, and setting the unable flag, when any of the following holds:
  - `req_ci` is 1;
  - `req_ct` is greater than 1;
  - `cache_en` is 0 and `req_ct` is 0;
  - `req_store` and `req_wt` are both 1.

  These checks take priority over hit and miss handling.
- R7: A lock-set with `req_ct`=1 that meets none of the R6 conditions returns none, changes no line and sets no flag.
- R8: Locking every way of a set through lock-set requests sets neither flag.
- R9: A fill returns bypass and changes no line when any of the following holds:
  - it misses in a set whose ways are all locked;
  - `req_ci` is 1;
  - `cache_en` is 0.
- R10: A lock-clear with `req_ct`=0 that hits clears that way's lock bit, returns hit, and makes the way eligible as a victim again. Any other lock-clear returns none and changes nothing.
- R11: Each flag stays set until its clear pulse. If a set event and a clear pulse for the same flag fall on the same edge, the flag ends up set. A flag never forces an exception output (there is none).
- R12: While `res_valid` is 1 and `res_ready` is 0, `req_ready` is 0 and `res_kind` and `res_way` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_type | input | 2 | Request kind (R2 encoding) |
| req_addr | input | 16 | Line address |
| req_ct | input | 5 | Cache-target operand (0 = this cache) |
| req_ci | input | 1 | Caching-inhibited attribute |
| req_wt | input | 1 | Write-through attribute |
| req_store | input | 1 | Store-variant lock request |
| cache_en | input | 1 | Cache enable |
| clr_overlock | input | 1 | Clear pulse for the overlock flag |
| clr_unable | input | 1 | Clear pulse for the unable flag |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_kind | output | 2 | Outcome: none, hit, alloc, bypass |
| res_way | output | 2 | Way for hit and alloc results |
| overlock_flag | output | 1 | Sticky: lock attempted into a fully locked set |
| unable_flag | output | 1 | Sticky: illegal lock attempt |

## Verification
A corrupted lock bit or pointer in this block stays hidden until a later request. It shows at the ports only when that request misses in the same set and needs a victim. At that point `res_way` names a different way than expected, a locked way is evicted, or a fill bypasses where it should allocate. Most such errors appear within a few requests to the affected set, so the sweep drives every set through a long mixed sequence and compares each result against a model.

A lost flag event shows on `overlock_flag` or `unable_flag` one edge after the request is accepted. A flag that fails to hold shows as soon as a later vector samples it without a clear pulse.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    RQ_FILL = 2'd0,
    RQ_LSET = 2'd1,
    RQ_LCLR = 2'd2,
    RQ_RSVD = 2'd3
  } rq_e;

  typedef enum logic [1:0] {
    RS_NONE   = 2'd0,
    RS_HIT    = 2'd1,
    RS_ALLOC  = 2'd2,
    RS_BYPASS = 2'd3
  } rs_e;
endpackage

// File: rtl/cl_tag_store.sv
module cl_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_lock,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAY_W-1:0]            rd_ptr,
  input  logic                        wr_alloc,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_lock,
  input  logic                        lk_wr,
  input  logic [WAY_W-1:0]            lk_way,
  input  logic                        lk_val
);
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            lock_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAY_W-1:0]           ptr_q   [SETS];
  logic [WAY_W-1:0]           ptr_next;

  assign rd_valid = valid_q[rd_set];
  assign rd_lock  = lock_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_ptr   = ptr_q[rd_set];
  assign ptr_next = WAY_W'((32'(wr_way) + 32'd1) % WAYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lock_q[s]  <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (wr_alloc) begin
        valid_q[rd_set][wr_way] <= 1'b1;
        lock_q[rd_set][wr_way]  <= wr_lock;
        ptr_q[rd_set]           <= ptr_next;
      end else if (lk_wr) begin
        lock_q[rd_set][lk_way] <= lk_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_alloc) tag_q[rd_set][wr_way] <= wr_tag;
  end

  // R4: a locked way is always a valid way
  assert_lock_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock & ~rd_valid) == '0);
endmodule

// File: rtl/cl_victim.sv
module cl_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  lock,
  input  logic [WAY_W-1:0] ptr,
  output logic             found,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    found = 1'b0;
    way   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid[i]) begin
        found = 1'b1;
        way   = WAY_W'(i);
      end
    end
    for (int i = 0; i < WAYS; i++) begin
      int idx;
      idx = (int'(ptr) + i) % WAYS;
      if (!found && !lock[idx]) begin
        found = 1'b1;
        way   = WAY_W'(idx);
      end
    end
  end
endmodule

// File: rtl/cl_sticky.sv
module cl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_flag_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o);
  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
endmodule

// File: rtl/cl_lock_ctrl.sv
module cl_lock_ctrl #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int CT_W   = 5,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CT_W-1:0]   req_ct,
  input  logic              req_ci,
  input  logic              req_wt,
  input  logic              req_store,
  input  logic              cache_en,
  input  logic              clr_overlock,
  input  logic              clr_unable,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_kind,
  output logic [WAY_W-1:0]  res_way,
  output logic              overlock_flag,
  output logic              unable_flag
);
  import cl_pkg::*;

  logic                       accept;
  logic [SET_W-1:0]           set_idx;
  logic [TAG_W-1:0]           tag;
  logic [WAYS-1:0]            rd_valid, rd_lock, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAY_W-1:0]           rd_ptr, vic_way, hit_way;
  logic                       vic_found, hit, lock_fail, ct_here;
  logic                       wr_alloc, wr_lock, lk_wr, lk_val, set_ovl, set_una;
  logic [WAY_W-1:0]           lk_way;
  rs_e                        nk;
  logic [WAY_W-1:0]           nway;
  rq_e                        rq;

  assign rq        = rq_e'(req_type);
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;
  assign set_idx   = req_addr[OFF_W +: SET_W];
  assign tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign ct_here   = (req_ct == '0);
  assign lock_fail = req_ci || (req_ct > CT_W'(1)) || (!cache_en && ct_here)
                     || (req_store && req_wt);

  cl_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W))
  u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(set_idx),
    .rd_valid(rd_valid), .rd_lock(rd_lock), .rd_tag(rd_tag), .rd_ptr(rd_ptr),
    .wr_alloc(wr_alloc), .wr_way(vic_way), .wr_tag(tag), .wr_lock(wr_lock),
    .lk_wr(lk_wr), .lk_way(lk_way), .lk_val(lk_val)
  );

  cl_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid(rd_valid), .lock(rd_lock), .ptr(rd_ptr), .found(vic_found), .way(vic_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == tag);
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    nk       = RS_NONE;
    nway     = '0;
    wr_alloc = 1'b0;
    wr_lock  = 1'b0;
    lk_wr    = 1'b0;
    lk_val   = 1'b0;
    lk_way   = hit_way;
    set_ovl  = 1'b0;
    set_una  = 1'b0;
    if (accept) begin
      unique case (rq)
        RQ_FILL: begin
          if (req_ci || !cache_en) nk = RS_BYPASS;
          else if (hit) begin
            nk   = RS_HIT;
            nway = hit_way;
          end else if (vic_found) begin
            nk       = RS_ALLOC;
            nway     = vic_way;
            wr_alloc = 1'b1;
          end else nk = RS_BYPASS;
        end
        RQ_LSET: begin
          if (lock_fail) set_una = 1'b1;
          else if (ct_here) begin
            if (hit) begin
              nk     = RS_HIT;
              nway   = hit_way;
              lk_wr  = 1'b1;
              lk_val = 1'b1;
            end else if (vic_found) begin
              nk       = RS_ALLOC;
              nway     = vic_way;
              wr_alloc = 1'b1;
              wr_lock  = 1'b1;
            end else set_ovl = 1'b1;
          end
        end
        RQ_LCLR: begin
          if (ct_here && hit) begin
            nk    = RS_HIT;
            nway  = hit_way;
            lk_wr = 1'b1;
          end
        end
        default: nk = RS_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= RS_NONE;
      res_way   <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_kind  <= nk;
      res_way   <= nway;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  cl_sticky u_ovl (.clk(clk), .rst_n(rst_n), .set_i(set_ovl), .clr_i(clr_overlock),
                   .flag_o(overlock_flag));
  cl_sticky u_una (.clk(clk), .rst_n(rst_n), .set_i(set_una), .clr_i(clr_unable),
                   .flag_o(unable_flag));

  assert_victim_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vic_found |-> !rd_lock[vic_way]);
  assert_result_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_kind) && $stable(res_way));
  assert_full_fill_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rq == RQ_FILL && !hit && (&rd_lock) |=> res_kind == RS_BYPASS);
  assert_overlock_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rq == RQ_LSET && !lock_fail && ct_here && !hit && (&rd_lock)
    |=> overlock_flag && res_kind == RS_NONE);
  assert_fail_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rq == RQ_LSET && lock_fail |=> unable_flag && res_kind == RS_NONE);
endmodule

// File: tb/cl_lock_ctrl_bench.sv
module cl_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_ci = 0, req_wt = 0, req_store = 0, cache_en = 1;
  logic clr_overlock = 0, clr_unable = 0, res_ready = 1;
  logic [1:0] req_type = 0;
  logic [15:0] req_addr = 0;
  logic [4:0] req_ct = 0;
  logic req_ready, res_valid, overlock_flag, unable_flag;
  logic [1:0] res_kind, res_way;

  int vecs = 0, errs = 0;
  bit mv [16][4];
  bit ml [16][4];
  logic [7:0] mt [16][4];
  int mp [16];
  bit eo = 0, eu = 0;

  always #5 clk = ~clk;

  cl_lock_ctrl u_cl_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .req_ct(req_ct), .req_ci(req_ci),
    .req_wt(req_wt), .req_store(req_store), .cache_en(cache_en),
    .clr_overlock(clr_overlock), .clr_unable(clr_unable), .res_valid(res_valid),
    .res_ready(res_ready), .res_kind(res_kind), .res_way(res_way),
    .overlock_flag(overlock_flag), .unable_flag(unable_flag)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string rq, input string msg);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s", rq, msg);
    end
  endtask

  function automatic int victim(int s);
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    for (int i = 0; i < 4; i++) if (!ml[s][(mp[s] + i) % 4]) return (mp[s] + i) % 4;
    return -1;
  endfunction

  function automatic int hitw(int s, logic [7:0] tg);
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == tg) return w;
    return -1;
  endfunction

  // kinds: 0 none, 1 hit, 2 alloc, 3 bypass
  task automatic model(input int t, input int s, input logic [7:0] tg, input int ct,
                       input bit ci, wt, st, en, output int k, output int w);
    int h, v;
    bit fail;
    h = hitw(s, tg);
    v = victim(s);
    k = 0; w = 0;
    fail = ci || ct > 1 || (!en && ct == 0) || (st && wt);
    if (t == 0) begin
      if (ci || !en) k = 3;
      else if (h >= 0) begin k = 1; w = h; end
      else if (v >= 0) begin
        k = 2; w = v; mv[s][v] = 1; ml[s][v] = 0; mt[s][v] = tg; mp[s] = (v + 1) % 4;
      end else k = 3;
    end else if (t == 1) begin
      if (fail) eu = 1;
      else if (ct == 0) begin
        if (h >= 0) begin k = 1; w = h; ml[s][h] = 1; end
        else if (v >= 0) begin
          k = 2; w = v; mv[s][v] = 1; ml[s][v] = 1; mt[s][v] = tg; mp[s] = (v + 1) % 4;
        end else eo = 1;
      end
    end else if (t == 2) begin
      if (ct == 0 && h >= 0) begin k = 1; w = h; ml[s][h] = 0; end
    end
  endtask

  task automatic req(input int t, input int s, input logic [7:0] tg, input int ct,
                     input bit ci, wt, st, en, input bit cu, input string rq);
    int k, w;
    @(negedge clk);
    req_type = 2'(t); req_addr = {tg, 4'(s), 4'h0}; req_ct = 5'(ct);
    req_ci = ci; req_wt = wt; req_store = st; cache_en = en;
    req_valid = 1; clr_unable = cu;
    if (cu) eu = 0;
    model(t, s, tg, ct, ci, wt, st, en, k, w);
    @(negedge clk);
    req_valid = 0; clr_unable = 0;
    chk(res_valid && res_kind == 2'(k) && ((k != 1 && k != 2) || res_way == 2'(w))
        && overlock_flag == eo && unable_flag == eu, rq,
        $sformatf("set %0d tag %0h type %0d: actual v=%0b k=%0d w=%0d o=%0b u=%0b expected v=1 k=%0d w=%0d o=%0b u=%0b",
                  s, tg, t, res_valid, res_kind, res_way, overlock_flag, unable_flag,
                  k, w, eo, eu));
  endtask

  task automatic clr(input bit o, input bit u);
    @(negedge clk);
    clr_overlock = o; clr_unable = u;
    @(negedge clk);
    clr_overlock = 0; clr_unable = 0;
    if (o) eo = 0;
    if (u) eu = 0;
    chk(overlock_flag == eo && unable_flag == eu, "R11",
        $sformatf("clear: actual o=%0b u=%0b expected o=%0b u=%0b",
                  overlock_flag, unable_flag, eo, eu));
  endtask

  initial begin
    int k, w;
    for (int s = 0; s < 16; s++) begin
      mp[s] = 0;
      for (int ww = 0; ww < 4; ww++) begin mv[s][ww] = 0; ml[s][ww] = 0; mt[s][ww] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!res_valid && req_ready && !overlock_flag && !unable_flag, "R1",
        $sformatf("reset: actual v=%0b r=%0b o=%0b u=%0b expected 0 1 0 0",
                  res_valid, req_ready, overlock_flag, unable_flag));

    // R12 back-pressure
    @(negedge clk);
    res_ready = 0; req_type = 0; req_addr = {8'hEE, 4'd15, 4'h0}; req_ct = 0;
    req_ci = 0; req_wt = 0; req_store = 0; cache_en = 1; req_valid = 1;
    model(0, 15, 8'hEE, 0, 0, 0, 0, 1, k, w);
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    chk(res_valid && !req_ready && res_kind == 2'd2 && res_way == 2'(w), "R12",
        $sformatf("stall: actual v=%0b r=%0b k=%0d w=%0d expected 1 0 2 %0d",
                  res_valid, req_ready, res_kind, res_way, w));
    res_ready = 1;
    @(negedge clk);
    chk(!res_valid && req_ready, "R12",
        $sformatf("drain: actual v=%0b r=%0b expected 0 1", res_valid, req_ready));

    for (int s = 0; s < 16; s++) begin
      logic [7:0] tb;
      tb = 8'(s * 11);
      for (int i = 0; i < 4; i++) req(0, s, tb + 8'(i), 0, 0, 0, 0, 1, 0, "R2");
      req(0, s, tb + 8'd4, 0, 0, 0, 0, 1, 0, "R2");
      req(0, s, tb + 8'd4, 0, 0, 0, 0, 1, 0, "R3");
      req(1, s, tb + 8'd1, 0, 0, 0, 0, 1, 0, "R4");
      req(0, s, tb + 8'd5, 0, 0, 0, 0, 1, 0, "R2");
      req(1, s, tb + 8'd6, 0, 0, 0, 0, 1, 0, "R4");
      req(1, s, tb + 8'd4, 0, 0, 0, 0, 1, 0, "R4");
      req(1, s, tb + 8'd7, 0, 0, 0, 0, 1, 0, "R8");
      req(1, s, tb + 8'd8, 0, 0, 0, 0, 1, 0, "R5");
      clr(1, 0);
      req(0, s, tb + 8'd9, 0, 0, 0, 0, 1, 0, "R9");
      req(1, s, tb + 8'd9, 0, 1, 0, 0, 1, 0, "R6");
      clr(0, 1);
      req(1, s, tb + 8'd9, 2 + s, 0, 0, 0, 1, 0, "R6");
      clr(0, 1);
      req(1, s, tb + 8'd9, 0, 0, 0, 0, 0, 0, "R6");
      req(1, s, tb + 8'd9, 0, 0, 1, 1, 1, 1, "R11");
      clr(0, 1);
      req(1, s, tb + 8'd9, 0, 0, 1, 0, 1, 0, "R6");
      req(1, s, tb + 8'd9, 1, 0, 0, 0, 1, 0, "R7");
      req(2, s, tb + 8'd9, 0, 0, 0, 0, 1, 0, "R10");
      req(2, s, tb + 8'd1, 1, 0, 0, 0, 1, 0, "R10");
      req(2, s, tb + 8'd1, 0, 0, 0, 0, 1, 0, "R10");
      req(0, s, tb + 8'd10, 0, 0, 0, 0, 1, 0, "R10");
      req(0, s, tb + 8'd4, 0, 1, 0, 0, 1, 0, "R9");
      req(0, s, tb + 8'd4, 0, 0, 0, 0, 0, 0, "R9");
      req(3, s, tb + 8'd11, 0, 0, 0, 0, 1, 0, "R3");
      req(0, s, tb + 8'd12, 0, 0, 0, 0, 1, 0, "R9");
    end
    finish_run();
  end
endmodule